// File: doc/BRIEF.md
# Programmable Interval Timer

A free-running up-counter that a processor reaches through a three-register bus interface. The counter advances by one on every clock and, after it equals a programmable limit, returns to zero on the next step. Each such expiry sets a sticky pending flag. Depending on the control settings, the flag then raises a level interrupt or, in watchdog mode, produces a reset request pulse. Software cannot stop the counter. It can enable or suppress the interrupt, make counting depend on a CPU-halted input, and write the count directly to move the next expiry.

The bus is a simple request port with valid, write, a 2-bit register address, write data, and registered read data. Address 0 selects the count register, 1 selects the control register and 2 selects the limit register. Address 3 is unused and reads as zero.

Top module: `interval_timer`

## Requirements
- R1: After reset the count is 0, the control register is 0 and the limit is all ones; irq and wdt_reset are low.
- R2: In a cycle where the counter advances, the count is not written and the count differs from the limit, the count rises by one, wrapping from all ones to zero without an expiry.
- R3: In a cycle where the counter advances, the count is not written and the count equals the limit, the next count is 0 and the pending flag (control bit 3) is set at the same edge.
- R4: With limit N-1 and no bus writes, expiries recur exactly every N cycles.
- R5: When control bit 1 is 1 and cpu_halted is high, the count holds. When control bit 1 is 0, the count advances regardless of cpu_halted.
- R6: Writing control with bit 3 = 0 clears the pending flag, unless an expiry occurs in the same cycle, in which case the flag stays set. Writing bit 3 = 1 never sets the flag. Only an expiry sets it.
- R7: irq is high exactly while the pending flag and control bit 0 (interrupt enable) are both 1 and control bit 2 (watchdog) is 0.
- R8: While control bit 2 is 1, irq stays low. wdt_reset is high for one cycle following each expiry, in the cycle in which the pending flag first shows that expiry.
- R9: A count write takes priority over the increment. The written value is the count in the next cycle, and no expiry is taken in the write cycle.
- R10: A read returns the addressed register's value, as it was at the request edge, on rd_data one cycle after the request. Control reads as {pending, watchdog, halt-gate, irq-enable} in bits 3..0, and address 3 reads 0.
- R11: Clearing interrupt enable only masks irq; the counter keeps running and the pending flag keeps being set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Register select: 0 count, 1 control, 2 limit |
| req_wdata | input | CNT_W | Write data |
| rd_data | output | CNT_W | Read data, one cycle after a read request |
| cpu_halted | input | 1 | High while the processor core is halted |
| irq | output | 1 | Level interrupt request |
| wdt_reset | output | 1 | Watchdog reset request pulse |

## Verification
The bench builds the timer with CNT_W = 8, which puts a wrap of the counter at its full range within a few hundred cycles. That makes it possible to cover both the natural wrap from all ones to zero and the reset-default limit of all ones. A table of limit, start count and wait length is checked against hand-computed count and pending values, including limit 0 and a start count above the limit. Directed tests then cover the expiry period in watchdog mode, the halt gating, the interrupt masking, the pending-clear rules and the collision between a count write and an expiry.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

  typedef enum logic [1:0] {
    REG_COUNT = 2'd0,
    REG_CTRL  = 2'd1,
    REG_LIMIT = 2'd2,
    REG_NONE  = 2'd3
  } reg_sel_e;

  // control layout, bit 3 down to bit 0
  typedef struct packed {
    logic pend;
    logic wdog;
    logic halt_gate;
    logic irq_en;
  } tmr_ctrl_t;

  localparam int CTRL_W = 4;

  function automatic logic irq_level(input tmr_ctrl_t c);
    return c.pend & c.irq_en & ~c.wdog;
  endfunction

  function automatic logic count_advances(input tmr_ctrl_t c, input logic halted);
    return ~(c.halt_gate & halted);
  endfunction

  function automatic logic pend_next(input logic cur, input logic expiry,
                                     input logic wr, input logic wbit);
    logic n;
    n = cur;
    if (wr && !wbit) n = 1'b0;
    if (expiry) n = 1'b1;
    return n;
  endfunction

endpackage

// File: rtl/itmr_counter.sv
module itmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_val,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             expiry
);

  logic [CNT_W-1:0] count_q;

  function automatic logic [CNT_W-1:0] step_count(
    input logic [CNT_W-1:0] cur,
    input logic [CNT_W-1:0] lim,
    input logic             adv,
    input logic             wr,
    input logic [CNT_W-1:0] val
  );
    if (wr) return val;
    if (!adv) return cur;
    if (cur == lim) return '0;
    return cur + 1'b1;
  endfunction

  assign expiry = advance && !wr_en && (count_q == limit);
  assign count  = count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= step_count(count_q, limit, advance, wr_en, wr_val);
  end

endmodule

// File: rtl/itmr_ctrl.sv
module itmr_ctrl
  import itmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctrl_wr,
  input  logic [CTRL_W-1:0]   ctrl_wdata,
  input  logic                lim_wr,
  input  logic [CNT_W-1:0]    lim_wdata,
  input  logic                expiry,
  output tmr_ctrl_t           ctrl,
  output logic [CNT_W-1:0]    limit
);

  tmr_ctrl_t        ctrl_q;
  logic [CNT_W-1:0] limit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q.wdog      <= ctrl_wdata[2];
        ctrl_q.halt_gate <= ctrl_wdata[1];
        ctrl_q.irq_en    <= ctrl_wdata[0];
      end
      ctrl_q.pend <= pend_next(ctrl_q.pend, expiry, ctrl_wr, ctrl_wdata[3]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      limit_q <= '1;
    else if (lim_wr) limit_q <= lim_wdata;
  end

  assign ctrl  = ctrl_q;
  assign limit = limit_q;

endmodule

// File: rtl/itmr_rdport.sv
module itmr_rdport
  import itmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  reg_sel_e         sel,
  input  logic [CNT_W-1:0] count,
  input  tmr_ctrl_t        ctrl,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] rd_data
);

  localparam int PAD_W = CNT_W - CTRL_W;

  logic [CNT_W-1:0] rd_q;
  logic [CNT_W-1:0] ctrl_ext;

  assign ctrl_ext = {{PAD_W{1'b0}}, ctrl};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_en) begin
      unique case (sel)
        REG_COUNT: rd_q <= count;
        REG_CTRL:  rd_q <= ctrl_ext;
        REG_LIMIT: rd_q <= limit;
        default:   rd_q <= '0;
      endcase
    end
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import itmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [1:0]       req_addr,
  input  logic [CNT_W-1:0] req_wdata,
  output logic [CNT_W-1:0] rd_data,
  input  logic             cpu_halted,
  output logic             irq,
  output logic             wdt_reset
);

  reg_sel_e         sel;
  logic             cnt_wr, ctrl_wr, lim_wr, rd_en;
  logic             advance, expiry;
  logic [CNT_W-1:0] count_q, limit_q;
  tmr_ctrl_t        ctrl_q;
  logic             wdt_q;

  assign sel     = reg_sel_e'(req_addr);
  assign cnt_wr  = req_valid && req_write && (sel == REG_COUNT);
  assign ctrl_wr = req_valid && req_write && (sel == REG_CTRL);
  assign lim_wr  = req_valid && req_write && (sel == REG_LIMIT);
  assign rd_en   = req_valid && !req_write;
  assign advance = count_advances(ctrl_q, cpu_halted);

  itmr_counter #(.CNT_W(CNT_W)) counter_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (advance),
    .wr_en   (cnt_wr),
    .wr_val  (req_wdata),
    .limit   (limit_q),
    .count   (count_q),
    .expiry  (expiry)
  );

  itmr_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .ctrl_wdata (req_wdata[CTRL_W-1:0]),
    .lim_wr     (lim_wr),
    .lim_wdata  (req_wdata),
    .expiry     (expiry),
    .ctrl       (ctrl_q),
    .limit      (limit_q)
  );

  itmr_rdport #(.CNT_W(CNT_W)) rdport_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .sel     (sel),
    .count   (count_q),
    .ctrl    (ctrl_q),
    .limit   (limit_q),
    .rd_data (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wdt_q <= 1'b0;
    else        wdt_q <= expiry && ctrl_q.wdog;
  end

  assign wdt_reset = wdt_q;
  assign irq       = irq_level(ctrl_q);

endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             advance,
  input logic             cnt_wr,
  input logic             lim_rd,
  input logic [CNT_W-1:0] wdata,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] lim,
  input logic             pend,
  input logic             wdog,
  input logic             irq,
  input logic             wdt_reset,
  input logic [CNT_W-1:0] rd_data
);

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !cnt_wr && cnt != lim) |=> (cnt == $past(cnt) + 1'b1));

  a_r3_wrap_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !cnt_wr && cnt == lim) |=> (cnt == '0 && pend));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !cnt_wr) |=> $stable(cnt));

  a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt == $past(wdata)));

  a_r6_set_by_expiry_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(advance && !cnt_wr && cnt == lim));

  a_r8_no_irq_in_wdog: assert property (@(posedge clk) disable iff (!rst_n)
    wdog |-> !irq);

  a_r8_pulse_source: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |-> $past(wdog && advance && !cnt_wr && cnt == lim));

  a_r10_limit_read: assert property (@(posedge clk) disable iff (!rst_n)
    lim_rd |=> (rd_data == $past(lim)));

endmodule

bind interval_timer interval_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .advance   (advance),
  .cnt_wr    (cnt_wr),
  .lim_rd    (rd_en && (sel == itmr_pkg::REG_LIMIT)),
  .wdata     (req_wdata),
  .cnt       (count_q),
  .lim       (limit_q),
  .pend      (ctrl_q.pend),
  .wdog      (ctrl_q.wdog),
  .irq       (irq),
  .wdt_reset (wdt_reset),
  .rd_data   (rd_data)
);

// File: tb/interval_timer_tb_top.sv
module interval_timer_tb_top;

  localparam int W = 8;
  localparam int NV = 7;
  // limit, start, cycles, expected count, expected pending
  localparam int TBL [NV][5] = '{
    '{9,   0,   5,   5, 0},
    '{9,   0,   10,  0, 1},
    '{9,   7,   2,   9, 1},
    '{3,   0,   9,   1, 1},
    '{255, 250, 10,  4, 1},
    '{5,   20,  240, 4, 0},
    '{0,   0,   3,   0, 1}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_write = 1'b0;
  logic [1:0]   req_addr = 2'd0;
  logic [W-1:0] req_wdata = '0;
  logic [W-1:0] rd_data;
  logic         cpu_halted = 1'b0;
  logic         irq;
  logic         wdt_reset;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  interval_timer #(.CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
    .cpu_halted(cpu_halted), .irq(irq), .wdt_reset(wdt_reset)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input int d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = W'(d);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output int d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = int'(rd_data);
  endtask

  task automatic finish_run;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int v;
    int t1, t2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, and R10: address 3 reads zero
    check("R1 irq", int'(irq), 0);
    check("R1 wdt_reset", int'(wdt_reset), 0);
    bus_rd(2'd0, v); check("R1 count", v, 0);
    bus_rd(2'd1, v); check("R1 control", v, 0);
    bus_rd(2'd2, v); check("R1 limit", v, 255);
    bus_rd(2'd3, v); check("R10 unused address", v, 0);

    // R2 R3 R10: table of limit/start/wait with expected count and pending
    for (int i = 0; i < NV; i++) begin
      bus_wr(2'd2, TBL[i][0]);
      bus_wr(2'd0, TBL[i][1]);
      bus_wr(2'd1, 0);
      repeat (TBL[i][2] - 1) @(negedge clk);
      bus_rd(2'd0, v);
      check($sformatf("R2/R3 row %0d count", i), v, TBL[i][3]);
      bus_rd(2'd1, v);
      check($sformatf("R3 row %0d pending", i), (v >> 3) & 1, TBL[i][4]);
    end

    // R4 R8: period 5 in watchdog mode, single pulses, no irq
    bus_wr(2'd2, 4);
    bus_wr(2'd0, 0);
    bus_wr(2'd1, 5);   // watchdog + irq enable
    t1 = -1; t2 = -1;
    for (int i = 0; i < 30 && t2 < 0; i++) begin
      if (wdt_reset) begin
        if (t1 < 0) t1 = i; else t2 = i;
        check("R8 irq masked in watchdog", int'(irq), 0);
      end
      @(negedge clk);
      if (t1 == i) check("R8 pulse width", int'(wdt_reset), 0);
    end
    check("R4 expiry period", t2 - t1, 5);
    bus_rd(2'd1, v);
    check("R10 control layout", v, 8'hD);

    // R7 R6 R11: interrupt behaviour
    bus_wr(2'd2, 200);
    bus_wr(2'd0, 198);
    bus_wr(2'd1, 1);   // ie, clear pending; count now 199
    check("R7 irq low before expiry", int'(irq), 0);
    @(negedge clk);    // count 200
    @(negedge clk);    // expiry taken
    check("R7 irq after expiry", int'(irq), 1);
    bus_wr(2'd1, 9);   // write 1 to pending: no change
    check("R6 write one keeps pending", int'(irq), 1);
    bus_wr(2'd1, 1);   // write 0 to pending
    check("R6 clear pending", int'(irq), 0);
    bus_wr(2'd1, 9);
    bus_rd(2'd1, v);
    check("R6 write one never sets", (v >> 3) & 1, 0);
    bus_wr(2'd0, 50);
    bus_wr(2'd1, 0);   // ie off; count 51
    repeat (9) @(negedge clk);
    bus_rd(2'd0, v);
    check("R11 counter runs with ie off", v, 60);
    bus_wr(2'd0, 200);
    @(negedge clk);    // expiry at this edge
    bus_rd(2'd1, v);
    check("R11 pending still set with ie off", (v >> 3) & 1, 1);
    check("R7 irq masked by ie", int'(irq), 0);

    // R5: halt gating
    bus_wr(2'd2, 255);
    bus_wr(2'd1, 2);
    cpu_halted = 1'b1;
    bus_wr(2'd0, 10);
    repeat (5) @(negedge clk);
    bus_rd(2'd0, v);
    check("R5 hold while halted", v, 10);
    bus_wr(2'd1, 0);
    bus_wr(2'd0, 10);
    repeat (5) @(negedge clk);
    bus_rd(2'd0, v);
    check("R5 run while halted when gate off", v, 15);
    cpu_halted = 1'b0;

    // R9: count write at limit suppresses that cycle's expiry
    bus_wr(2'd2, 20);
    bus_wr(2'd1, 0);
    bus_wr(2'd0, 20);
    bus_wr(2'd0, 20);  // count==limit at this edge, but write wins
    bus_rd(2'd1, v);   // expiry at this edge, sampled before
    check("R9 no expiry on write cycle", (v >> 3) & 1, 0);
    bus_rd(2'd1, v);
    check("R3 expiry after write", (v >> 3) & 1, 1);
    bus_rd(2'd0, v);
    check("R9 count after wrap", v, 1);

    finish_run();
  end

endmodule